// File: doc/BRIEF.md
# Microprogram Sequencer with Return Stack

This block computes the control-store address of the next microword for a horizontally microcoded processor. It holds no incrementing program counter: each microword supplies a base target address and a condition-group select, and the sequencer merges the chosen condition bits into the low-order bits of the target. The result is a jump of two, four, eight or sixteen ways in a single microcycle. One address is produced per clock and held in a register that drives the control store.

The sequencer also keeps a sixteen-entry return stack for nested microsubroutines. It takes entry addresses from two external dispatch lookups: one indexed by opcode and one indexed by operand specifier. It diverts to a fixed service address when an event is pending at instruction dispatch. A microtrap input forces a jump to a fixed trap vector and records the address of the interrupted microword. A dedicated return operation later reloads that address so the faulting microword runs again.

Top module: `mseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, `addr_o` becomes 0, the return stack is emptied and `stk_err_o` clears.
- R2: Operation code 0 (branch) with `but_i` = 0 loads `nxt_i` unchanged into `addr_o`. Codes 6 and 7 behave like code 0.
- R3: With `but_i` = g (1 to 7), group g is `cond_i[4g-1:4g-4]`. Its four bits are ORed into bits 3:0 of `nxt_i` to form the target of codes 0 and 1.
- R4: Code 1 (call) jumps to the merged target and pushes `addr_o`+1, modulo 2^14. Code 2 (return) pops the most recent entry and loads it into `addr_o`.
- R5: The stack holds 16 return addresses. A push while it holds 16 discards the oldest entry, keeps the newest 16 in last-in first-out order, and sets `stk_err_o`.
- R6: A return on an empty stack loads 0 and sets `stk_err_o`. The flag stays set until reset.
- R7: Code 3 (instruction dispatch) loads `idisp_i` when `pend_i` is low, and loads the service vector 0x0008 when `pend_i` is high.
- R8: Code 4 (operand dispatch) loads `odisp_i`.
- R9: When `utrap_i` is high, the next address is the trap vector 0x0004 whatever the operation code. No push or pop takes place, and the current `addr_o` is saved.
- R10: Code 5 (trap return) loads the address saved by the most recent microtrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Microcycle clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Sequencing operation of the current microword |
| but_i | input | 3 | Condition-group select of the current microword |
| nxt_i | input | 14 | Base target address of the current microword |
| cond_i | input | 28 | Seven 4-bit condition groups |
| idisp_i | input | 14 | Address from the opcode-indexed lookup |
| odisp_i | input | 14 | Address from the operand-indexed lookup |
| pend_i | input | 1 | Interrupt or trap pending at instruction dispatch |
| utrap_i | input | 1 | Microtrap request |
| addr_o | output | 14 | Current control-store address |
| stk_err_o | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The bench drives condition groups so that each select shows a distinct pattern. A mux that picks the wrong group, or ORs into the wrong bit positions, yields a different address. It makes seventeen nested calls and then unwinds them. A stack that refuses the extra push, or drops the wrong end, returns the wrong sequence; one that wraps its pointer badly returns stale data on the final empty pop. A microtrap is raised while the microword asks for a return. A design that lets the operation through would pop the stack, and one that saves the wrong address would send the trap return elsewhere. A call from the top of the address space checks that the return address wraps to zero.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  typedef enum logic [2:0] {
    OP_BR    = 3'd0,
    OP_CALL  = 3'd1,
    OP_RET   = 3'd2,
    OP_IDISP = 3'd3,
    OP_ODISP = 3'd4,
    OP_TRET  = 3'd5
  } mseq_op_e;
endpackage

// File: rtl/mseq_cond_sel.sv
module mseq_cond_sel #(
  parameter int CW   = 4,
  parameter int NGRP = 7,
  parameter int SW   = 3
) (
  input  logic [SW-1:0]      sel,
  input  logic [NGRP*CW-1:0] cond,
  output logic [CW-1:0]      grp
);
  logic [CW-1:0] grp_arr [NGRP+1];

  assign grp_arr[0] = '0;
  for (genvar g = 1; g <= NGRP; g++) begin : g_grp
    assign grp_arr[g] = cond[(g-1)*CW +: CW];
  end

  always_comb begin
    grp = '0;
    for (int k = 0; k <= NGRP; k++) begin
      if (int'(sel) == k) grp = grp_arr[k];
    end
  end
endmodule

// File: rtl/mseq_stack.sv
module mseq_stack #(
  parameter int AW    = 14,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  output logic          err
);
  localparam int PW = $clog2(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [PW:0]   cnt_q;
  logic          full, empty, ovf_ev, unf_ev;

  assign full   = (cnt_q == (PW+1)'(DEPTH));
  assign empty  = (cnt_q == '0);
  assign ovf_ev = push && full;
  assign unf_ev = pop && !push && empty;
  assign rdata  = empty ? '0 : mem[ptr_q - 1'b1];

  always_ff @(posedge clk) begin
    if (push) mem[ptr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      cnt_q <= '0;
      err   <= 1'b0;
    end else if (push) begin
      ptr_q <= ptr_q + 1'b1;
      if (full) err <= 1'b1;
      else      cnt_q <= cnt_q + 1'b1;
    end else if (pop) begin
      if (empty) err <= 1'b1;
      else begin
        ptr_q <= ptr_q - 1'b1;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R5
  overflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_ev |=> err);
  // R6
  underflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
    unf_ev |=> err);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    full && push |=> full);
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int              AW       = 14,
  parameter int              DEPTH    = 16,
  parameter int              CW       = 4,
  parameter int              NGRP     = 7,
  parameter int              SW       = 3,
  parameter logic [AW-1:0]   TRAP_VEC = 14'h0004,
  parameter logic [AW-1:0]   SVC_VEC  = 14'h0008
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           op_i,
  input  logic [SW-1:0]        but_i,
  input  logic [AW-1:0]        nxt_i,
  input  logic [NGRP*CW-1:0]   cond_i,
  input  logic [AW-1:0]        idisp_i,
  input  logic [AW-1:0]        odisp_i,
  input  logic                 pend_i,
  input  logic                 utrap_i,
  output logic [AW-1:0]        addr_o,
  output logic                 stk_err_o
);
  function automatic logic [AW-1:0] merge_cond(input logic [AW-1:0] base,
                                               input logic [CW-1:0] c);
    return base | {{(AW-CW){1'b0}}, c};
  endfunction

  function automatic logic [AW-1:0] ret_of(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  mseq_op_e      op;
  logic [CW-1:0] grp_bits;
  logic [AW-1:0] merged, stk_top, next_addr, saved_q;
  logic          do_push, do_pop;

  assign op = mseq_op_e'(op_i);

  mseq_cond_sel #(.CW(CW), .NGRP(NGRP), .SW(SW)) u_csel (
    .sel (but_i),
    .cond(cond_i),
    .grp (grp_bits)
  );

  assign merged = merge_cond(nxt_i, grp_bits);

  mseq_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk  (clk),
    .rst  (rst),
    .push (do_push),
    .pop  (do_pop),
    .wdata(ret_of(addr_o)),
    .rdata(stk_top),
    .err  (stk_err_o)
  );

  always_comb begin
    do_push   = 1'b0;
    do_pop    = 1'b0;
    next_addr = merged;
    if (utrap_i) begin
      next_addr = TRAP_VEC;
    end else begin
      case (op)
        OP_CALL:  begin do_push = 1'b1; next_addr = merged; end
        OP_RET:   begin do_pop  = 1'b1; next_addr = stk_top; end
        OP_IDISP: next_addr = pend_i ? SVC_VEC : idisp_i;
        OP_ODISP: next_addr = odisp_i;
        OP_TRET:  next_addr = saved_q;
        default:  next_addr = merged;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      saved_q <= '0;
    end else begin
      addr_o <= next_addr;
      if (utrap_i) saved_q <= addr_o;
    end
  end

  // R9
  trap_vector_chk: assert property (@(posedge clk) disable iff (rst)
    utrap_i |=> addr_o == TRAP_VEC);
  // R9
  trap_save_chk: assert property (@(posedge clk) disable iff (rst)
    utrap_i |=> saved_q == $past(addr_o));
  // R9
  trap_no_stack_chk: assert property (@(posedge clk) disable iff (rst)
    utrap_i |-> !do_push && !do_pop);
  // R2
  plain_jump_chk: assert property (@(posedge clk) disable iff (rst)
    !utrap_i && op_i == 3'd0 && but_i == '0 |=> addr_o == $past(nxt_i));
  // R8
  odisp_chk: assert property (@(posedge clk) disable iff (rst)
    !utrap_i && op_i == 3'd4 |=> addr_o == $past(odisp_i));
  // R7
  svc_divert_chk: assert property (@(posedge clk) disable iff (rst)
    !utrap_i && op_i == 3'd3 && pend_i |=> addr_o == SVC_VEC);
  // R10
  trap_return_chk: assert property (@(posedge clk) disable iff (rst)
    !utrap_i && op_i == 3'd5 |=> addr_o == $past(saved_q));
endmodule

// File: tb/mseq_top_tb.sv
module mseq_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_i = '0;
  logic [2:0]  but_i = '0;
  logic [13:0] nxt_i = '0;
  logic [27:0] cond_i = '0;
  logic [13:0] idisp_i = '0;
  logic [13:0] odisp_i = '0;
  logic        pend_i = 1'b0;
  logic        utrap_i = 1'b0;
  logic [13:0] addr_o;
  logic        stk_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mseq_top u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .but_i(but_i), .nxt_i(nxt_i),
    .cond_i(cond_i), .idisp_i(idisp_i), .odisp_i(odisp_i), .pend_i(pend_i),
    .utrap_i(utrap_i), .addr_o(addr_o), .stk_err_o(stk_err_o)
  );

  // but, nxt, cond, expected address; all with operation code 0
  localparam logic [58:0] VEC [6] = '{
    {3'd0, 14'h0100, 28'hFFFFFFF, 14'h0100},
    {3'd1, 14'h0100, 28'h0000005, 14'h0105},
    {3'd2, 14'h0200, 28'h00000A0, 14'h020A},
    {3'd7, 14'h3FF0, 28'h3000000, 14'h3FF3},
    {3'd3, 14'h0013, 28'h0000C00, 14'h001F},
    {3'd4, 14'h0000, 28'hFFF0FFF, 14'h0000}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [2:0] but,
                      input logic [13:0] nxt, input logic [27:0] cnd,
                      input logic trap);
    @(negedge clk);
    op_i = op; but_i = but; nxt_i = nxt; cond_i = cnd; utrap_i = trap;
    @(posedge clk);
    #3;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_i = '0; utrap_i = 1'b0; pend_i = 1'b0;
    @(posedge clk); @(posedge clk);
    #3;
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [13:0] rets [17];
    logic [13:0] prev;
    do_reset();
    // R1
    chk("R1 addr after reset", int'(addr_o), 0);
    chk("R1 err after reset", int'(stk_err_o), 0);

    for (int i = 0; i < 6; i++) begin
      step(3'd0, VEC[i][58:56], VEC[i][55:42], VEC[i][41:14], 1'b0);
      chk(VEC[i][58:56] == 3'd0 ? "R2 plain jump" : "R3 merged branch",
          int'(addr_o), int'(VEC[i][13:0]));
    end
    // R2 codes 6 and 7 act as branch
    step(3'd6, 3'd0, 14'h0777, 28'h0, 1'b0);
    chk("R2 code6", int'(addr_o), 14'h0777);
    step(3'd7, 3'd1, 14'h0770, 28'h0000009, 1'b0);
    chk("R2 code7", int'(addr_o), 14'h0779);

    // R4 call/return with merged target
    do_reset();
    step(3'd0, 3'd0, 14'h0400, 28'h0, 1'b0);
    step(3'd1, 3'd1, 14'h0500, 28'h0000002, 1'b0);
    chk("R4 call target", int'(addr_o), 14'h0502);
    // R9 trap overrides a return: no pop
    step(3'd2, 3'd0, 14'h0, 28'h0, 1'b1);
    chk("R9 trap vector", int'(addr_o), 14'h0004);
    // R10 trap return
    step(3'd5, 3'd0, 14'h0, 28'h0, 1'b0);
    chk("R10 trap return", int'(addr_o), 14'h0502);
    step(3'd2, 3'd0, 14'h0, 28'h0, 1'b0);
    chk("R4 return after trap", int'(addr_o), 14'h0401);
    chk("R9 no stack error", int'(stk_err_o), 0);
    // R4 wrap of return address
    step(3'd0, 3'd0, 14'h3FFF, 28'h0, 1'b0);
    step(3'd1, 3'd0, 14'h0100, 28'h0, 1'b0);
    step(3'd2, 3'd0, 14'h0, 28'h0, 1'b0);
    chk("R4 wrapped return", int'(addr_o), 0);

    // R7 / R8 dispatch
    @(negedge clk); idisp_i = 14'h2345; odisp_i = 14'h1ABC; pend_i = 1'b0;
    step(3'd3, 3'd0, 14'h0, 28'h0, 1'b0);
    chk("R7 dispatch", int'(addr_o), 14'h2345);
    @(negedge clk); pend_i = 1'b1;
    step(3'd3, 3'd0, 14'h0, 28'h0, 1'b0);
    chk("R7 service divert", int'(addr_o), 14'h0008);
    step(3'd3, 3'd0, 14'h0, 28'h0, 1'b1);
    chk("R9 trap beats dispatch", int'(addr_o), 14'h0004);
    @(negedge clk); pend_i = 1'b0;
    step(3'd4, 3'd0, 14'h0, 28'h0, 1'b0);
    chk("R8 operand dispatch", int'(addr_o), 14'h1ABC);

    // R6 empty pop
    do_reset();
    step(3'd2, 3'd0, 14'h0, 28'h0, 1'b0);
    chk("R6 empty pop addr", int'(addr_o), 0);
    chk("R6 empty pop err", int'(stk_err_o), 1);

    // R5 overflow
    do_reset();
    prev = 14'h0;
    for (int i = 0; i < 17; i++) begin
      rets[i] = prev + 14'd1;
      prev = 14'h0100 + 14'(2 * i);
      step(3'd1, 3'd0, prev, 28'h0, 1'b0);
      if (i == 15) chk("R5 no err at 16", int'(stk_err_o), 0);
    end
    chk("R5 err on overflow", int'(stk_err_o), 1);
    for (int j = 16; j >= 1; j--) begin
      step(3'd2, 3'd0, 14'h0, 28'h0, 1'b0);
      chk("R5 lifo order", int'(addr_o), int'(rets[j]));
    end
    step(3'd2, 3'd0, 14'h0, 28'h0, 1'b0);
    chk("R5 oldest discarded", int'(addr_o), 0);
    step(3'd0, 3'd0, 14'h0033, 28'h0, 1'b0);
    chk("R6 err sticky", int'(stk_err_o), 1);
    do_reset();
    chk("R1 err cleared", int'(stk_err_o), 0);
    step(3'd2, 3'd0, 14'h0, 28'h0, 1'b0);
    chk("R1 stack emptied", int'(addr_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule